// File: doc/BRIEF.md
# Bit Clock Recovery Loop with Two-Speed Phase Correction

This block regenerates the bit clock of a serial receiver from sliced, hard-decided demodulated data. A free-running phase counter splits each bit into sixteen phase units. Every transition on the incoming data is compared with the point where the counter wraps. The counter is then pulled back when the transition came late in the bit, or pushed forward when it came early. The regenerated clock is high for the first half of the count and low for the second half. Received data is captured at the bit centre, at the falling edge of that clock, and is held until the next falling edge.

The correction step adapts to the error. While the error is larger than one phase unit (22.5 degrees) and fast correction is enabled, the loop takes large steps. Once the error is within one unit, it drops at once to single-unit steps. A lock-profile input chooses between a quick acquisition, which must settle within 18 bits of alternating data, and a gentler one, which may take up to 50 bits. The gentler profile uses smaller large steps and applies a single-unit step only on every second eligible transition. A prescaler divides the sample clock so that one bit period is 16, 32 or 64 sample-clock cycles (times a base divider), giving the three supported bit rates.

Top module: `bit_clock_recovery`

## Requirements
- R1: While reset is asserted, `rclk` is 1 and `rd_out` is 0.
- R2: With no data transitions, `rclk` has a period of 16·BASE_DIV sample-clock cycles for `rate_sel`=0, 32·BASE_DIV for 1, and 64·BASE_DIV for 2 or 3, and it is high for exactly half of each period.
- R3: A data transition seen at phase p (0..15, where 0 is the wrap point) has error magnitude p for p in 1..7 (late: the counter is retarded) and 16−p for p in 8..15 (early: the counter is advanced). A transition at p=0 causes no correction, and the next bit's transition is then again seen at phase 0.
- R4: When `fast_en`=1 and the error magnitude exceeds 1, the correction is min(S, magnitude), with S=4 for `lock_sel`=0 and S=2 for `lock_sel`=1.
- R5: When `fast_en`=0, or when the magnitude is exactly 1, the correction is one unit on each transition under `lock_sel`=0.
- R6: Under `lock_sel`=1, single-unit corrections are applied only on every second eligible transition: the first is skipped and the next is applied, counting from reset. A large step neither counts toward nor clears this alternation.
- R7: From any starting phase, with alternating data, the transition phase is within one unit of 0 by the 18th bit for `lock_sel`=0 and by the 50th bit for `lock_sel`=1.
- R8: `rd_out` takes the value of `rx_data` at the sample-clock edge where `rclk` falls, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-rate choice: 0 full rate, 1 half rate, 2 or 3 quarter rate |
| fast_en | input | 1 | Enables large correction steps while the error exceeds one unit |
| lock_sel | input | 1 | 0 selects quick acquisition, 1 selects the gentler profile |
| rx_data | input | 1 | Sliced receive data |
| rclk | output | 1 | Regenerated bit clock |
| rd_out | output | 1 | Retimed receive data, updated on the falling edge of `rclk` |

## Verification
On every cycle the assertions check several properties. A correction never exceeds the measured error and never exceeds one unit when fast mode is off. Only fast mode may take more than one unit. The phase counter advances by exactly one on a tick with no transition, and the clock only moves on a tick. The prescaler never ticks twice in a row at the divided rates, and the retimed data changes only where the clock falls. Other behaviour spans many bits and can only be shown by the bench's scenarios. These cover the exact sequence of transition phases bit after bit, for every starting phase and every mode pair. They also cover the skipped-then-applied pattern of slow steps, the lock budgets of 18 and 50 bits, and the clock period at each rate. Finally, the bench checks that recovered data matches a pseudo-random stream once the loop has locked.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef enum logic [1:0] {
    CORR_NONE,
    CORR_HOLD,
    CORR_SLOW,
    CORR_FAST
  } corr_kind_e;

  // Distance of a transition phase from the wrap point, in phase units.
  function automatic int unsigned err_mag(input int unsigned p, input int unsigned phases);
    if (p == 0) return 0;
    else if (p < phases / 2) return p;
    else return phases - p;
  endfunction

  // A transition in the first half of the count arrived after the wrap point.
  function automatic logic is_late(input int unsigned p, input int unsigned phases);
    return (p != 0) && (p < phases / 2);
  endfunction

  function automatic int unsigned clamp_step(input int unsigned want, input int unsigned mag);
    return (want < mag) ? want : mag;
  endfunction

  // Sample-clock cycles per phase tick for each rate setting.
  function automatic int unsigned tick_div(input int unsigned base, input logic [1:0] sel);
    case (sel)
      2'd0:    return base;
      2'd1:    return base * 2;
      default: return base * 4;
    endcase
  endfunction

endpackage

// File: rtl/bcr_tick_gen.sv
module bcr_tick_gen #(
  parameter int BASE_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  import bcr_pkg::*;

  localparam int CW = $clog2(BASE_DIV * 4 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div_m1;

  always_comb begin
    div_m1 = CW'(tick_div(BASE_DIV, rate_sel) - 1);
    tick   = (cnt_q >= div_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  // R2: at a divided rate two ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_sel != 2'd0) |=> (!tick || rate_sel == 2'd0));

endmodule

// File: rtl/bcr_phase_ctrl.sv
module bcr_phase_ctrl #(
  parameter int PH_BITS        = 4,
  parameter int FAST_STEP      = 4,
  parameter int FAST_STEP_LONG = 2,
  parameter int SLOW_SKIP      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rx,
  input  logic               fast_en,
  input  logic               lock_sel,
  output logic [PH_BITS-1:0] phase_nxt
);
  import bcr_pkg::*;

  localparam int PHASES = 1 << PH_BITS;
  localparam int SK_W   = $clog2(SLOW_SKIP) + 1;

  logic [PH_BITS-1:0] phase_q;
  logic               prev_rx_q;
  logic [SK_W-1:0]    skip_q;

  // Named internal events used by the assertions.
  logic               edge_seen;
  logic               late;
  logic [PH_BITS-1:0] mag;
  logic [PH_BITS-1:0] corr_amt;
  corr_kind_e         kind;

  always_comb begin
    edge_seen = tick && (rx != prev_rx_q);
    mag       = PH_BITS'(err_mag(32'(phase_q), PHASES));
    late      = is_late(32'(phase_q), PHASES);
    kind      = CORR_NONE;
    corr_amt  = '0;
    if (edge_seen && mag != '0) begin
      if (fast_en && mag > PH_BITS'(1)) begin
        kind     = CORR_FAST;
        corr_amt = PH_BITS'(clamp_step(lock_sel ? FAST_STEP_LONG : FAST_STEP, 32'(mag)));
      end else if (lock_sel && skip_q != SK_W'(SLOW_SKIP - 1)) begin
        kind     = CORR_HOLD;
      end else begin
        kind     = CORR_SLOW;
        corr_amt = PH_BITS'(1);
      end
    end
    if (!tick)     phase_nxt = phase_q;
    else if (late) phase_nxt = phase_q + PH_BITS'(1) - corr_amt;
    else           phase_nxt = phase_q + PH_BITS'(1) + corr_amt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= '0;
      prev_rx_q <= 1'b0;
      skip_q    <= '0;
    end else begin
      phase_q <= phase_nxt;
      if (tick) prev_rx_q <= rx;
      if (kind == CORR_HOLD)                  skip_q <= skip_q + 1'b1;
      else if (kind == CORR_SLOW && lock_sel) skip_q <= '0;
    end
  end

  // R5: without fast mode the loop never moves more than one unit
  a_r5_slow_only: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !fast_en) |-> (corr_amt <= PH_BITS'(1)));

  // R4: a multi-unit step needs fast mode and an error above one unit
  a_r4_fast_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_amt > PH_BITS'(1)) |-> (fast_en && mag > PH_BITS'(1)));

  // R4: no step overshoots the measured error
  a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |-> (corr_amt <= mag));

  // R3: without a transition the counter advances by one per tick
  a_r3_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !edge_seen) |=> (phase_q == $past(phase_q) + PH_BITS'(1)));

  // R6: a skipped slow step happens only under the gentle profile
  a_r6_hold_profile: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CORR_HOLD) |-> (lock_sel && corr_amt == '0));

endmodule

// File: rtl/bcr_retime.sv
module bcr_retime #(
  parameter int PH_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PH_BITS-1:0] phase_nxt,
  input  logic               rx,
  output logic               rclk,
  output logic               rd
);
  localparam int HALF = (1 << PH_BITS) / 2;

  logic rclk_d;
  logic fall;

  always_comb begin
    rclk_d = (phase_nxt < PH_BITS'(HALF));
    fall   = rclk && !rclk_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rclk <= 1'b1;
      rd   <= 1'b0;
    end else begin
      rclk <= rclk_d;
      if (fall) rd <= rx;
    end
  end

  // R8: retimed data moves only where the clock falls
  a_r8_rd_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd) |-> $fell(rclk));

  // R2: the clock only moves on a phase tick
  a_r2_clock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rclk));

endmodule

// File: rtl/bit_clock_recovery.sv
module bit_clock_recovery #(
  parameter int BASE_DIV       = 1,
  parameter int PH_BITS        = 4,
  parameter int FAST_STEP      = 4,
  parameter int FAST_STEP_LONG = 2,
  parameter int SLOW_SKIP      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       fast_en,
  input  logic       lock_sel,
  input  logic       rx_data,
  output logic       rclk,
  output logic       rd_out
);

  logic               tick;
  logic [PH_BITS-1:0] phase_nxt;

  bcr_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .tick     (tick)
  );

  bcr_phase_ctrl #(
    .PH_BITS        (PH_BITS),
    .FAST_STEP      (FAST_STEP),
    .FAST_STEP_LONG (FAST_STEP_LONG),
    .SLOW_SKIP      (SLOW_SKIP)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rx        (rx_data),
    .fast_en   (fast_en),
    .lock_sel  (lock_sel),
    .phase_nxt (phase_nxt)
  );

  bcr_retime #(.PH_BITS(PH_BITS)) u_retime (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .phase_nxt (phase_nxt),
    .rx        (rx_data),
    .rclk      (rclk),
    .rd        (rd_out)
  );

endmodule

// File: tb/bit_clock_recovery_test.sv
module bit_clock_recovery_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       fast_en = 1'b0;
  logic       lock_sel = 1'b0;
  logic       rx_data = 1'b0;
  logic       rclk;
  logic       rd_out;

  int  vectors = 0;
  int  misses = 0;
  bit  done = 1'b0;

  bit_clock_recovery uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .fast_en  (fast_en),
    .lock_sel (lock_sel),
    .rx_data  (rx_data),
    .rclk     (rclk),
    .rd_out   (rd_out)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: samples one time unit after each rising edge.
  int  cyc = 0;
  int  last_rise = 0;
  int  last_period = 0;
  int  last_high = 0;
  logic prev_rclk = 1'b1;
  bit  rd_chk = 1'b0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst_n) begin
      prev_rclk = rclk;
    end else begin
      if (rclk && !prev_rclk) begin
        last_period = cyc - last_rise;
        last_rise   = cyc;
      end
      if (!rclk && prev_rclk) begin
        last_high = cyc - last_rise;
        if (rd_chk) check(rd_out == rx_data, "R8 retimed data", int'(rd_out), int'(rx_data));
      end
      prev_rclk = rclk;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    rx_data = 1'b0;
    repeat (3) @(negedge clk);
    check(rclk == 1'b1, "R1 reset rclk", int'(rclk), 1);
    check(rd_out == 1'b0, "R1 reset rd_out", int'(rd_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_rate(input int rs);
    int shift;
    shift    = (rs == 0) ? 0 : (rs == 1) ? 1 : 2;
    rate_sel = 2'(rs);
    fast_en  = 1'b1;
    lock_sel = 1'b0;
    do_reset();
    repeat (300) @(negedge clk);
    check(last_period == (16 << shift), "R2 clock period", last_period, 16 << shift);
    check(last_high == (8 << shift), "R2 clock high time", last_high, 8 << shift);
  endtask

  task automatic run_lock(input int o, input bit fe, input bit ls);
    int    p, pm, mag, step, skip, budget;
    bit    late;
    string tag;
    logic [7:0] lfsr;
    rate_sel = 2'd0;
    fast_en  = fe;
    lock_sel = ls;
    do_reset();
    repeat (20 + o) @(negedge clk);
    budget = ls ? 50 : 18;
    skip   = 0;
    pm     = 0;
    tag    = "R3";
    for (int k = 0; k < 60; k++) begin
      p = (cyc - last_rise) % 16;
      if (k > 0) check(p == pm, {tag, " phase after correction"}, p, pm);
      if (k == budget) check(p <= 1 || p >= 15, "R7 lock budget", p, 0);
      mag  = (p == 0) ? 0 : (p < 8) ? p : 16 - p;
      late = (p != 0) && (p < 8);
      if (mag == 0) begin
        step = 0; tag = "R3";
      end else if (fe && mag > 1) begin
        step = ((ls ? 2 : 4) < mag) ? (ls ? 2 : 4) : mag;
        tag  = "R4";
      end else if (ls && skip == 0) begin
        step = 0; skip = 1; tag = "R6";
      end else begin
        step = 1; tag = ls ? "R6" : "R5";
        if (ls) skip = 0;
      end
      pm = late ? ((p - step + 16) % 16) : ((p + step) % 16);
      rx_data = ~rx_data;
      repeat (16) @(negedge clk);
    end
    lfsr   = 8'(o * 17 + 5);
    rd_chk = 1'b1;
    for (int b = 0; b < 24; b++) begin
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rx_data = lfsr[0];
      repeat (16) @(negedge clk);
    end
    rd_chk = 1'b0;
  endtask

  initial begin
    for (int rs = 0; rs < 4; rs++) run_rate(rs);
    for (int fe = 0; fe < 2; fe++)
      for (int ls = 0; ls < 2; ls++)
        for (int o = 0; o < 16; o++)
          run_lock(o, fe[0], ls[0]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule